// File: doc/BRIEF.md
# Horizontal Drive Watchdog

This block sits behind the horizontal drive pulse of a display deflection stage and keeps that drive safe. It runs from a 5 MHz reference clock, where one count is 200 ns. It times every period of the incoming drive pulse, measured from one rising edge to the next, and also times how long the pulse spends low within that period. Both figures are checked against a control range. A two-bit frequency select picks one of four period bands. A select pin picks a main window, and the chosen band is clipped so that it lies inside that window.

While the incoming pulse keeps meeting the range, it is passed to the output one clock later. When a period, an off-time or a missing edge breaks the rules, the output switches to a free-running drive pulse divided down from the reference clock. That pulse keeps the output stage switching at a safe rate until the incoming signal has been good for four periods in a row. Both changeovers fall on a rising edge of the output, so no runt pulse is produced. An optional hold keeps the output high for as long as the flyback pulse is present. As a result, the output cannot fall before flyback ends.

All pins are plain control levels. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `hdrv_watchdog`

## Requirements
- R1: While `rst_n` is low, `fallback` is 1 and `drv_out` is 0. In the first cycle after release the free-running pulse starts with its high phase.
- R2: The main window is 144..172 counts when `win_sel`=0 and 128..146 counts when `win_sel`=1. The `freq_sel` bands are 0: 156..172, 1: 144..160, 2: 132..146 and 3: 120..136. The active range takes the larger of the two lower bounds and the smaller of the two upper bounds. If that leaves the lower bound above the upper bound, the main window is used unchanged.
- R3: A measured period, counted from one rising edge of `drv_in` to the next, is valid only if it lies within the active range, both ends included.
- R4: The low time within a measured period is valid only if 2·P ≤ 5·L ≤ 3·P, that is 40 % to 60 % of the period P, both ends included.
- R5: The free-running pulse has period P = floor((lo+hi)/2) of the active range. It is low for floor(P/2) counts and high for the remaining counts, and each period starts with the high phase.
- R6: From fallback, the block returns to pass-through at the rising edge of `drv_in` that completes the fourth valid period in a row. The first rising edge after reset or after a timeout only starts a measurement.
- R7: In pass-through mode, when the hold is not active, `drv_out` equals `drv_in` one clock later.
- R8: An invalid period or off-time in pass-through mode selects fallback at once. The free-running pulse restarts so that `drv_out` is high in the next cycle. Any invalid measurement clears the count of valid periods.
- R9: If no rising edge arrives within hi+16 counts of the previous one, this counts as a violation. The next rising edge then only starts a new measurement.
- R10: With `flb_hold_en`=1, `drv_out` is 1 in the cycle after any cycle in which `flyback_in` is 1. With `flb_hold_en`=0, `flyback_in` has no effect on `drv_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 5 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_sel | input | 1 | Main window select pin |
| freq_sel | input | 2 | Period band select |
| flb_hold_en | input | 1 | Enables holding the output high during flyback |
| flyback_in | input | 1 | Flyback pulse, active high |
| drv_in | input | 1 | Monitored horizontal drive pulse |
| drv_out | output | 1 | Drive pulse sent to the output stage |
| fallback | output | 1 | 1 while the free-running pulse is selected |

## Verification
The main function is driven with trains of pulses whose period and low time sit exactly on each bound of the active range and one count outside it. This shows whether each comparison includes its end point. The same trains are applied with every band and both window pins, including the combinations whose band misses the window entirely, which separates correct clipping from a plain band lookup. Directed sequences then stop the edges to trigger a timeout, feed three and then four good periods to pin down the recovery count, and slip in one short period while in pass-through. A flyback pulse is placed across a falling edge, with the hold enabled and then disabled, to show that the hold acts only when enabled.

// File: rtl/hdrv_wd_pkg.sv
package hdrv_wd_pkg;
  localparam int CNT_W = 9;
  localparam int DEF_STREAK_N = 4;
  localparam int DEF_TMO_MARGIN = 16;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic {MODE_BACKUP = 1'b0, MODE_PASS = 1'b1} mode_e;

  // main windows, in reference counts
  localparam cnt_t WIN_SLOW_LO = cnt_t'(144);
  localparam cnt_t WIN_SLOW_HI = cnt_t'(172);
  localparam cnt_t WIN_FAST_LO = cnt_t'(128);
  localparam cnt_t WIN_FAST_HI = cnt_t'(146);

  function automatic cnt_t band_lo(input logic [1:0] sel);
    case (sel)
      2'd0:    return cnt_t'(156);
      2'd1:    return cnt_t'(144);
      2'd2:    return cnt_t'(132);
      default: return cnt_t'(120);
    endcase
  endfunction

  function automatic cnt_t band_hi(input logic [1:0] sel);
    case (sel)
      2'd0:    return cnt_t'(172);
      2'd1:    return cnt_t'(160);
      2'd2:    return cnt_t'(146);
      default: return cnt_t'(136);
    endcase
  endfunction
endpackage

// File: rtl/hdrv_wd_range.sv
module hdrv_wd_range
  import hdrv_wd_pkg::*;
#(
  parameter int TMO_MARGIN = DEF_TMO_MARGIN
) (
  input  logic       win_sel,
  input  logic [1:0] freq_sel,
  output cnt_t       lim_lo,
  output cnt_t       lim_hi,
  output cnt_t       tmo_lim,
  output cnt_t       gen_per,
  output cnt_t       gen_high
);
  cnt_t b_lo, b_hi, w_lo, w_hi, c_lo, c_hi, gen_low;
  logic [CNT_W:0] span_sum;

  always_comb begin
    b_lo = band_lo(freq_sel);
    b_hi = band_hi(freq_sel);
    w_lo = win_sel ? WIN_FAST_LO : WIN_SLOW_LO;
    w_hi = win_sel ? WIN_FAST_HI : WIN_SLOW_HI;
    c_lo = (b_lo > w_lo) ? b_lo : w_lo;
    c_hi = (b_hi < w_hi) ? b_hi : w_hi;
    // a band that misses the window falls back to the window itself
    if (c_lo > c_hi) begin
      lim_lo = w_lo;
      lim_hi = w_hi;
    end else begin
      lim_lo = c_lo;
      lim_hi = c_hi;
    end
    span_sum = {1'b0, lim_lo} + {1'b0, lim_hi};
    gen_per  = span_sum[CNT_W:1];
    gen_low  = {1'b0, gen_per[CNT_W-1:1]};
    gen_high = gen_per - gen_low;
    tmo_lim  = lim_hi + cnt_t'(TMO_MARGIN);
  end
endmodule

// File: rtl/hdrv_wd_meter.sv
module hdrv_wd_meter
  import hdrv_wd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drv_in,
  input  cnt_t lim_lo,
  input  cnt_t lim_hi,
  input  cnt_t tmo_lim,
  output logic rise,
  output logic meas_ok,
  output logic meas_bad
);
  localparam int WW = CNT_W + 3;
  localparam cnt_t CNT_MAX = '1;

  logic prev_q, have_ref_q;
  cnt_t per_q, low_q;
  logic [WW-1:0] low5, per2, per3;
  logic in_band, duty_ok, tmo_hit;

  always_comb begin
    rise     = drv_in & ~prev_q;
    low5     = (WW'(low_q) << 2) + WW'(low_q);
    per2     = WW'(per_q) << 1;
    per3     = per2 + WW'(per_q);
    in_band  = (per_q >= lim_lo) && (per_q <= lim_hi);
    duty_ok  = (low5 >= per2) && (low5 <= per3);
    tmo_hit  = !rise && (per_q == tmo_lim);
    meas_ok  = rise && have_ref_q && in_band && duty_ok;
    meas_bad = (rise && have_ref_q && !(in_band && duty_ok)) || tmo_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      have_ref_q <= 1'b0;
      per_q      <= '0;
      low_q      <= '0;
    end else begin
      prev_q <= drv_in;
      if (rise) begin
        per_q      <= cnt_t'(1);
        low_q      <= '0;
        have_ref_q <= 1'b1;
      end else begin
        if (per_q != CNT_MAX) per_q <= per_q + cnt_t'(1);
        if (!drv_in && low_q != CNT_MAX) low_q <= low_q + cnt_t'(1);
        if (tmo_hit) have_ref_q <= 1'b0;
      end
    end
  end

  // a timeout leaves the next edge as a bare reference
  p_no_eval_after_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !meas_ok);

  p_ok_bad_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_ok && meas_bad));
endmodule

// File: rtl/hdrv_wd_gen.sv
module hdrv_wd_gen
  import hdrv_wd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  cnt_t gen_per,
  input  cnt_t gen_high,
  output logic gen_lvl
);
  cnt_t ph_q;

  assign gen_lvl = restart || (ph_q < gen_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (restart) begin
      ph_q <= cnt_t'(1);
    end else if (ph_q >= gen_per - cnt_t'(1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + cnt_t'(1);
    end
  end

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(gen_per) |-> (ph_q < gen_per));
endmodule

// File: rtl/hdrv_watchdog.sv
module hdrv_watchdog
  import hdrv_wd_pkg::*;
#(
  parameter int STREAK_N   = DEF_STREAK_N,
  parameter int TMO_MARGIN = DEF_TMO_MARGIN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_sel,
  input  logic [1:0] freq_sel,
  input  logic       flb_hold_en,
  input  logic       flyback_in,
  input  logic       drv_in,
  output logic       drv_out,
  output logic       fallback
);
  localparam int SW = $clog2(STREAK_N + 1);

  cnt_t lim_lo, lim_hi, tmo_lim, gen_per, gen_high;
  logic rise, meas_ok, meas_bad, gen_lvl, restart, hold;
  mode_e mode_q, mode_nx;
  logic [SW-1:0] streak_q, streak_nx;

  hdrv_wd_range #(.TMO_MARGIN(TMO_MARGIN)) u_range (
    .win_sel(win_sel), .freq_sel(freq_sel), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .tmo_lim(tmo_lim), .gen_per(gen_per), .gen_high(gen_high)
  );

  hdrv_wd_meter u_meter (
    .clk(clk), .rst_n(rst_n), .drv_in(drv_in), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .tmo_lim(tmo_lim), .rise(rise), .meas_ok(meas_ok), .meas_bad(meas_bad)
  );

  hdrv_wd_gen u_gen (
    .clk(clk), .rst_n(rst_n), .restart(restart), .gen_per(gen_per),
    .gen_high(gen_high), .gen_lvl(gen_lvl)
  );

  always_comb begin
    hold = flb_hold_en & flyback_in;
    if (meas_bad)
      streak_nx = '0;
    else if (meas_ok && streak_q < SW'(STREAK_N))
      streak_nx = streak_q + SW'(1);
    else
      streak_nx = streak_q;

    mode_nx = mode_q;
    if (mode_q == MODE_PASS) begin
      if (meas_bad) mode_nx = MODE_BACKUP;
    end else if (meas_ok && streak_q == SW'(STREAK_N - 1)) begin
      mode_nx = MODE_PASS;
    end
    restart = (mode_q == MODE_PASS) && (mode_nx == MODE_BACKUP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_BACKUP;
      streak_q <= '0;
      drv_out  <= 1'b0;
    end else begin
      mode_q   <= mode_nx;
      streak_q <= streak_nx;
      drv_out  <= ((mode_nx == MODE_PASS) ? drv_in : gen_lvl) | hold;
    end
  end

  assign fallback = (mode_q == MODE_BACKUP);

  p_range_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_lo <= lim_hi) &&
    (lim_lo >= (win_sel ? WIN_FAST_LO : WIN_SLOW_LO)) &&
    (lim_hi <= (win_sel ? WIN_FAST_HI : WIN_SLOW_HI)));

  p_pass_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fallback) |-> ($past(rise) && drv_out));

  p_streak_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q <= SW'(STREAK_N));

  p_pass_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PASS && !$past(hold)) |-> (drv_out == $past(drv_in)));

  p_backup_starts_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback) |-> drv_out);

  p_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flb_hold_en && flyback_in) |=> drv_out);
endmodule

// File: tb/hdrv_watchdog_tb.sv
module hdrv_watchdog_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_sel = 1'b0;
  logic [1:0] freq_sel = 2'd0;
  logic flb_hold_en = 1'b0;
  logic flyback_in = 1'b0;
  logic drv_in = 1'b0;
  logic drv_out, fallback;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdrv_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .freq_sel(freq_sel),
    .flb_hold_en(flb_hold_en), .flyback_in(flyback_in), .drv_in(drv_in),
    .drv_out(drv_out), .fallback(fallback)
  );

  // kind: 0 period bound (R3), 1 off-time bound (R4), 2 clipped range (R2)
  typedef struct packed {
    logic       win;
    logic [1:0] fsel;
    logic [8:0] per;
    logic [8:0] low;
    logic       pass;
    logic [1:0] kind;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 9'd160, 9'd80, 1'b1, 2'd0},
    '{1'b0, 2'd0, 9'd150, 9'd75, 1'b0, 2'd0},
    '{1'b0, 2'd0, 9'd172, 9'd86, 1'b1, 2'd0},
    '{1'b0, 2'd0, 9'd173, 9'd86, 1'b0, 2'd0},
    '{1'b0, 2'd0, 9'd156, 9'd62, 1'b0, 2'd1},
    '{1'b0, 2'd0, 9'd156, 9'd63, 1'b1, 2'd1},
    '{1'b0, 2'd0, 9'd160, 9'd96, 1'b1, 2'd1},
    '{1'b0, 2'd0, 9'd160, 9'd97, 1'b0, 2'd1},
    '{1'b0, 2'd1, 9'd144, 9'd72, 1'b1, 2'd0},
    '{1'b0, 2'd1, 9'd143, 9'd72, 1'b0, 2'd0},
    '{1'b0, 2'd3, 9'd170, 9'd85, 1'b1, 2'd2},
    '{1'b1, 2'd2, 9'd140, 9'd70, 1'b1, 2'd2},
    '{1'b1, 2'd2, 9'd147, 9'd70, 1'b0, 2'd2},
    '{1'b1, 2'd3, 9'd128, 9'd64, 1'b1, 2'd2},
    '{1'b1, 2'd3, 9'd137, 9'd68, 1'b0, 2'd2},
    '{1'b1, 2'd0, 9'd146, 9'd73, 1'b1, 2'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drv_in = 1'b0;
    flyback_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int per, input int low);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      drv_in = (i < per - low);
    end
  endtask

  task automatic count_gen(input string tag, input int exp_hi, input int exp_lo);
    int hi = 0;
    int lo = 0;
    @(negedge clk);
    while (drv_out && hi < 400) begin hi++; @(negedge clk); end
    while (!drv_out && lo < 400) begin lo++; @(negedge clk); end
    chk(hi == exp_hi, {tag, " high phase"}, hi, exp_hi);
    chk(lo == exp_lo, {tag, " low phase"}, lo, exp_lo);
  endtask

  // flyback placed across the falling edge of one valid 160-count pulse
  task automatic fly_pulse(input bit en, input int exp86, input int exp96);
    flb_hold_en = en;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (i == 86) chk(drv_out == exp86[0], "R10 output during flyback", drv_out, exp86);
      if (i == 96) chk(drv_out == exp96[0], "R10 output after flyback", drv_out, exp96);
      drv_in = (i < 80);
      flyback_in = (i >= 70 && i < 90);
    end
    flyback_in = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(fallback == 1'b1, "R1 fallback in reset", fallback, 1);
    chk(drv_out == 1'b0, "R1 drv_out in reset", drv_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drv_out == 1'b1, "R1 first cycle high", drv_out, 1);

    // R5: free-running pulse, range 156..172 -> 164 (82/82)
    do_reset();
    count_gen("R5 even period", 82, 82);
    // R5: range 132..146 -> 139 (70 high / 69 low)
    win_sel = 1'b1; freq_sel = 2'd2;
    do_reset();
    count_gen("R5 odd period", 70, 69);

    // table of pulse trains: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      win_sel = VECS[v].win;
      freq_sel = VECS[v].fsel;
      do_reset();
      for (int k = 0; k < 7; k++) pulse(int'(VECS[v].per), int'(VECS[v].low));
      @(negedge clk);
      case (VECS[v].kind)
        2'd0: chk(fallback == !VECS[v].pass, "R3 period bound", fallback, !VECS[v].pass);
        2'd1: chk(fallback == !VECS[v].pass, "R4 off-time bound", fallback, !VECS[v].pass);
        default: chk(fallback == !VECS[v].pass, "R2 clipped range", fallback, !VECS[v].pass);
      endcase
      if (VECS[v].pass) chk(drv_out == 1'b0, "R7 pass-through level", drv_out, 0);
    end

    // R6 / R9 / R8: pass, loss of edges, recovery count, short period
    win_sel = 1'b0; freq_sel = 2'd0;
    do_reset();
    for (int k = 0; k < 6; k++) pulse(160, 80);
    chk(fallback == 1'b0, "R6 pass after valid train", fallback, 0);
    repeat (20) @(negedge clk);
    chk(fallback == 1'b0, "R9 no timeout before hi+16", fallback, 0);
    repeat (15) @(negedge clk);
    chk(fallback == 1'b1, "R9 timeout selects fallback", fallback, 1);
    chk(drv_out == 1'b1, "R8 fallback starts high", drv_out, 1);
    for (int k = 0; k < 4; k++) pulse(160, 80);
    chk(fallback == 1'b1, "R6 three valid periods not enough", fallback, 1);
    pulse(160, 80);
    chk(fallback == 1'b0, "R6 fourth valid period returns", fallback, 0);
    pulse(150, 75);
    @(negedge clk);
    drv_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(fallback == 1'b1, "R8 short period drops to fallback", fallback, 1);
    chk(drv_out == 1'b1, "R8 restart high", drv_out, 1);

    // R10: flyback hold enabled and disabled
    do_reset();
    for (int k = 0; k < 6; k++) pulse(160, 80);
    fly_pulse(1'b1, 1, 0);
    fly_pulse(1'b0, 0, 0);
    pulse(160, 80);
    chk(fallback == 1'b0, "R10 flyback leaves mode alone", fallback, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule